// File: doc/BRIEF.md
# Card Slot Interrupt Status Register

This block sits beside a memory card slot and turns the slot's two sense lines into register state and one interrupt. The write-protect level is brought into the clock domain and reported as it stands. The card-detect level is also brought in, but only its low-to-high change counts: that change latches a pending-card flag, which drives the interrupt line. The flag stays set until software writes a one to it, whatever the card-detect input does in the meantime.

Software reaches the block through a simple single-cycle register port with four word-sized registers. Word 0 holds a fixed identification value, word 1 belongs to flash programming, word 2 is the interrupt status register and word 3 holds a fixed decode value. Words 1 and 3 take writes without effect. Any access outside the four words, and any write to the identification word, is flagged as an access error. Read data and the error flag come back one clock after the request.

Top module: `slot_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge the pending-card flag, the synchronisers and the response registers clear, so after reset `irq_out` is 0 and word 2 reads 0.
- R2: A read of word 0 returns `ID_VALUE`, word 1 returns 0 and word 3 returns `DECODE_VALUE`, with `bus_err` low; the response appears on the clock after the request.
- R3: Status bit 0 equals the write-protect input after a synchroniser of `SYNC_STAGES` flops: 1 while `wp_in` is high, 0 while it is low.
- R4: A low-to-high change on `card_in` sets status bit 3 and raises `irq_out` exactly `SYNC_STAGES` + 1 clock edges after the input changes.
- R5: A high-to-low change on `card_in` leaves status bit 3 and `irq_out` unchanged.
- R6: A write to word 2 whose data bit 3 is 1 clears status bit 3, and `irq_out` falls on the same edge; a write to word 2 with data bit 3 at 0 changes nothing, and no write changes bit 0.
- R7: When a card rising edge and a clearing write to word 2 arrive at the same clock edge, status bit 3 ends set.
- R8: Writes to words 1 and 3 leave every register unchanged with `bus_err` low; a write to word 0 leaves it unchanged and raises `bus_err`.
- R9: Any access to a word index above 3 raises `bus_err` for the one response cycle, returns read data 0 and changes no state; `bus_err` is low on every cycle that follows no request.
- R10: Status bits other than bits 0 and 3 always read 0.
- R11: `irq_out` is 1 exactly when status bit 3 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_in | input | 1 | Write-protect level from the slot, asynchronous |
| card_in | input | 1 | Card-detect level from the slot, asynchronous |
| bus_sel | input | 1 | Register request valid for this cycle |
| bus_wr | input | 1 | 1 for a write request, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_err | output | 1 | Access error, one cycle after the request |
| irq_out | output | 1 | Card-inserted interrupt, active high |

## Verification
A wrongly held or wrongly cleared pending-card flag shows on `irq_out` at once and on the next read of word 2, so the bench watches the interrupt after every step and reads the status word often. A synchroniser or edge detector off by one stage shows as the interrupt rising one edge early or late, which a directed test pins to the exact edge. A decode fault shows in the following response cycle as wrong read data or a wrong error flag, and the random mix of legal, ignored and illegal accesses reaches every word.

// File: rtl/slot_irq_pkg.sv
// Package: word indices and bit positions shared by the card slot register block.
// Assumes a word-addressed register file whose byte address drops bits 1:0.
package slot_irq_pkg;
    localparam int WORD_ID    = 0;  // fixed identification value
    localparam int WORD_FLASH = 1;  // flash programming, reads zero
    localparam int WORD_STAT  = 2;  // interrupt status
    localparam int WORD_DEC   = 3;  // fixed decode value
    localparam int WORD_COUNT = 4;

    localparam int BIT_WP   = 0;    // write-protect level
    localparam int BIT_CARD = 3;    // sticky card-inserted flag

    typedef enum logic [1:0] {
        ACC_OK      = 2'd0,
        ACC_IGNORED = 2'd1,
        ACC_BAD     = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/slot_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes the input is a slow level signal; STAGES flops in series, reset to 0.
module slot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous level into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Pass the level one flop further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slot_status.sv
// Module: rising-edge detector and sticky pending-card flag.
// Assumes card_sync is already synchronised; a set and a clear in the same
// cycle leave the flag set so that no insertion is lost.
module slot_status (
    input  logic clk,
    input  logic rst_n,
    input  logic card_sync,
    input  logic clr_req,
    output logic card_rise,
    output logic card_pend
);
    logic card_prev;

    // Remember the previous synchronised card-detect level.
    always_ff @(posedge clk) begin
        if (!rst_n) card_prev <= 1'b0;
        else        card_prev <= card_sync;
    end

    assign card_rise = card_sync & ~card_prev;

    // Set on a new insertion, clear on a software request; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         card_pend <= 1'b0;
        else if (card_rise) card_pend <= 1'b1;
        else if (clr_req)   card_pend <= 1'b0;
    end

    // R4: a detected insertion latches the flag on the next edge.
    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rise |=> card_pend);

    // R5: without a clear request the flag never drops.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_pend && !clr_req) |=> card_pend);

    // R6: a clear request without a new insertion drops the flag.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !card_rise) |=> !card_pend);

    // R7: an insertion coinciding with a clear leaves the flag set.
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && card_rise) |=> card_pend);

    // R4: the flag only rises after a detected insertion.
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pend) |-> $past(card_rise));
endmodule

// File: rtl/slot_regs.sv
// Module: register decode, read multiplexer and response registers.
// Assumes one request per cycle on bus_sel; read data and error are
// registered and valid on the cycle after the request only.
module slot_regs
    import slot_irq_pkg::*;
#(
    parameter int              ADDR_W       = 8,
    parameter int              DATA_W       = 32,
    parameter logic [DATA_W-1:0] ID_VALUE     = 32'h1A2B_0C3D,
    parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wp_bit,
    input  logic              card_bit,
    output logic              clr_card,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_mux;
    acc_kind_t         kind;

    assign word = bus_addr[ADDR_W-1:2];

    // Assemble the status word from the two live bits.
    always_comb begin
        stat_word           = '0;
        stat_word[BIT_WP]   = wp_bit;
        stat_word[BIT_CARD] = card_bit;
    end

    // Classify the request and pick the read value for its word.
    always_comb begin
        rd_mux = '0;
        kind   = ACC_BAD;
        if (word == WORD_W'(WORD_ID)) begin
            rd_mux = ID_VALUE;
            kind   = bus_wr ? ACC_BAD : ACC_OK;
        end else if (word == WORD_W'(WORD_FLASH)) begin
            rd_mux = '0;
            kind   = bus_wr ? ACC_IGNORED : ACC_OK;
        end else if (word == WORD_W'(WORD_STAT)) begin
            rd_mux = stat_word;
            kind   = ACC_OK;
        end else if (word == WORD_W'(WORD_DEC)) begin
            rd_mux = DECODE_VALUE;
            kind   = bus_wr ? ACC_IGNORED : ACC_OK;
        end
    end

    assign clr_card = bus_sel & bus_wr & (word == WORD_W'(WORD_STAT)) & bus_wdata[BIT_CARD];

    // Register the response for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err   <= bus_sel & (kind == ACC_BAD);
            bus_rdata <= (bus_sel && !bus_wr && kind == ACC_OK) ? rd_mux : '0;
        end
    end

    // R9: an access beyond the last word answers with an error and zero data.
    assert_bad_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && word >= WORD_W'(WORD_COUNT)) |=> (bus_err && bus_rdata == '0));

    // R9: no request, no error in the following cycle.
    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err);

    // R2: the identification word returns its constant.
    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && word == WORD_W'(WORD_ID)) |=> (bus_rdata == ID_VALUE && !bus_err));

    // R10: a status read carries nothing outside bits 0 and 3.
    assert_stat_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && word == WORD_W'(WORD_STAT))
            |=> ((bus_rdata & ~((DATA_W'(1) << BIT_WP) | (DATA_W'(1) << BIT_CARD))) == '0));

    // R8: a write to the identification word is an access error.
    assert_id_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && word == WORD_W'(WORD_ID)) |=> bus_err);
endmodule

// File: rtl/slot_irq_ctrl.sv
// Module: card slot interrupt status block (top).
// Synchronises write-protect and card-detect, keeps a sticky card-inserted
// flag that drives irq_out, and serves four word registers.
// Assumes DATA_W > 3 and ADDR_W > 4.
module slot_irq_ctrl #(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 32,
    parameter int                SYNC_STAGES  = 2,
    parameter logic [DATA_W-1:0] ID_VALUE     = 32'h1A2B_0C3D,
    parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_in,
    input  logic              card_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq_out
);
    logic wp_sync;
    logic card_sync;
    logic card_rise;
    logic card_pend;
    logic clr_card;

    slot_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wp_in),
        .q_sync  (wp_sync)
    );

    slot_sync #(.STAGES(SYNC_STAGES)) u_card_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (card_in),
        .q_sync  (card_sync)
    );

    slot_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .card_sync (card_sync),
        .clr_req   (clr_card),
        .card_rise (card_rise),
        .card_pend (card_pend)
    );

    slot_regs #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .ID_VALUE     (ID_VALUE),
        .DECODE_VALUE (DECODE_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wp_bit    (wp_sync),
        .card_bit  (card_pend),
        .clr_card  (clr_card),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    assign irq_out = card_pend;

    // R8: writes to the ignored words leave the card flag alone.
    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !card_rise
            && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1) || bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3)))
            |=> $stable(card_pend));

    // R9: an out-of-range access leaves the card flag alone.
    assert_bad_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !card_rise && bus_addr[ADDR_W-1:2] > (ADDR_W-2)'(3)) |=> $stable(card_pend));
endmodule

// File: tb/tb_slot_irq_ctrl.sv
// Bench: directed corner cases, then seeded random operations checked
// against a bench model of the write-protect level and the card flag.
module tb_slot_irq_ctrl;
    localparam int          ADDR_W = 8;
    localparam int          DATA_W = 32;
    localparam logic [31:0] T_ID   = 32'h4100_0042;
    localparam logic [31:0] T_DEC  = 32'h0000_0A5C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_in = 1'b0;
    logic              card_in = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic              irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic m_wp   = 1'b0;
    logic m_pend = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    slot_irq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2),
        .ID_VALUE(T_ID), .DECODE_VALUE(T_DEC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .card_in(card_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input int w, input logic wp, input logic pend);
        case (w)
            0:       return T_ID;
            1:       return 32'h0;
            2:       return {28'h0, pend, 2'b00, wp};
            3:       return T_DEC;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a negedge; returns the response sampled one cycle later.
    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er);
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = wd;
        @(negedge clk);
        rd = bus_rdata;
        er = bus_err;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_stat(input string tag);
        logic [31:0] rd;
        logic er;
        access(1'b0, 8'h08, 32'h0, rd, er);
        chk(tag, rd, exp_read(2, m_wp, m_pend));
        chk(tag, {31'h0, er}, 32'h0);
        chk({tag, " irq"}, {31'h0, irq_out}, {31'h0, m_pend});
    endtask

    initial begin
        logic [31:0] rd;
        logic er;
        void'($urandom(32'd20240611));
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        chk("R1 err after reset", {31'h0, bus_err}, 32'h0);
        read_stat("R1 status after reset");

        // R2: fixed words
        access(1'b0, 8'h00, 32'h0, rd, er);
        chk("R2 id word", rd, T_ID);
        chk("R2 id err", {31'h0, er}, 32'h0);
        access(1'b0, 8'h04, 32'h0, rd, er);
        chk("R2 flash word", rd, 32'h0);
        access(1'b0, 8'h0C, 32'h0, rd, er);
        chk("R2 decode word", rd, T_DEC);

        // R3: write-protect follows the input
        wp_in = 1'b1; m_wp = 1'b1; settle(4);
        read_stat("R3 wp high");
        wp_in = 1'b0; m_wp = 1'b0; settle(4);
        read_stat("R3 wp low");

        // R4: insertion raises irq exactly three edges later
        card_in = 1'b1;
        settle(2);
        chk("R4 irq not yet", {31'h0, irq_out}, 32'h0);
        settle(1);
        chk("R4 irq raised", {31'h0, irq_out}, 32'h1);
        m_pend = 1'b1;
        read_stat("R4 card bit set");

        // R5: removal keeps the flag
        card_in = 1'b0; settle(5);
        read_stat("R5 after removal");

        // R6: write without bit 3 keeps it, with bit 3 clears it at once
        access(1'b1, 8'h08, 32'hFFFF_FFF7, rd, er);
        chk("R6 no clear irq", {31'h0, irq_out}, 32'h1);
        access(1'b1, 8'h08, 32'h0000_0008, rd, er);
        chk("R6 irq drops", {31'h0, irq_out}, 32'h0);
        m_pend = 1'b0;
        wp_in = 1'b1; m_wp = 1'b1; settle(4);
        access(1'b1, 8'h08, 32'hFFFF_FFFF, rd, er);
        read_stat("R6 wp unaffected by write");

        // R4: a second insertion latches again
        card_in = 1'b1; settle(4); m_pend = 1'b1;
        read_stat("R4 second insertion");
        access(1'b1, 8'h08, 32'h8, rd, er); m_pend = 1'b0;
        card_in = 1'b0; settle(4);

        // R7: clear coinciding with the detected edge
        card_in = 1'b1;
        settle(2);
        access(1'b1, 8'h08, 32'h8, rd, er);
        m_pend = 1'b1;
        chk("R7 set wins irq", {31'h0, irq_out}, 32'h1);
        read_stat("R7 set wins status");

        // R8: ignored and read-only words
        access(1'b1, 8'h04, 32'hFFFF_FFFF, rd, er);
        chk("R8 flash write err", {31'h0, er}, 32'h0);
        access(1'b1, 8'h0C, 32'hFFFF_FFFF, rd, er);
        chk("R8 decode write err", {31'h0, er}, 32'h0);
        access(1'b1, 8'h00, 32'h0, rd, er);
        chk("R8 id write err", {31'h0, er}, 32'h1);
        access(1'b0, 8'h0C, 32'h0, rd, er);
        chk("R8 decode unchanged", rd, T_DEC);
        access(1'b0, 8'h00, 32'h0, rd, er);
        chk("R8 id unchanged", rd, T_ID);
        read_stat("R8 status unchanged");

        // R9: out-of-range words
        access(1'b0, 8'h10, 32'h0, rd, er);
        chk("R9 bad read err", {31'h0, er}, 32'h1);
        chk("R9 bad read data", rd, 32'h0);
        access(1'b1, 8'hFC, 32'h8, rd, er);
        chk("R9 bad write err", {31'h0, er}, 32'h1);
        @(negedge clk);
        chk("R9 err one cycle", {31'h0, bus_err}, 32'h0);
        read_stat("R9 state untouched");

        // Random mix: R3 R4 R5 R6 R8 R9 R10 R11
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] v;
            op = $urandom_range(0, 5);
            v  = $urandom;
            case (op)
                0: begin
                    wp_in = ~wp_in; m_wp = wp_in; settle(4);
                end
                1: begin
                    logic nc;
                    nc = v[0];
                    if (nc && !card_in) m_pend = 1'b1;
                    card_in = nc; settle(4);
                end
                2: begin
                    access(1'b1, 8'h08, v, rd, er);
                    if (v[3]) m_pend = 1'b0;
                    chk("R6 random status write err", {31'h0, er}, 32'h0);
                end
                3: begin
                    access(1'b1, v[4] ? 8'h0C : 8'h04, v, rd, er);
                    chk("R8 random ignored write err", {31'h0, er}, 32'h0);
                end
                4: begin
                    int w;
                    w = $urandom_range(0, 3);
                    access(1'b0, 8'(w * 4), 32'h0, rd, er);
                    chk("R10 random read", rd, exp_read(w, m_wp, m_pend));
                    chk("R2 random read err", {31'h0, er}, 32'h0);
                end
                default: begin
                    logic [7:0] a;
                    a = 8'($urandom_range(4, 63) * 4);
                    access(v[5], a, v, rd, er);
                    chk("R9 random bad err", {31'h0, er}, 32'h1);
                    chk("R9 random bad data", rd, 32'h0);
                end
            endcase
            chk("R11 irq tracks flag", {31'h0, irq_out}, {31'h0, m_pend});
        end
        read_stat("R10 final status");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule